// File: doc/BRIEF.md
# Cascaded BCD Time-of-Day Counter

This block keeps hours, minutes and seconds as six BCD digits. It is built as a chain of digit stages. Each stage passes a carry to the next one when it is enabled and already holds its top value. The chain has three decimal stages, two base-six stages and a one-bit toggle for the hour tens. The count moves forward by one second on each rising clock edge while the count-enable input is high. A one-second strobe driving that enable (or a one-second clock) therefore turns the block into a wall clock.

The counted range runs from 00:00:00 up to 12:00:00. The value 12:00:00 is shown for one enabled cycle, and the next enabled edge brings every digit back to zero. Each digit also drives an active-high seven-segment pattern. In both output buses the hour tens digit sits in the most significant (leftmost) field and the second units digit in the least significant field.

Top module: `tod_counter`

## Requirements
- R1: The second units, minute units and hour units digits are decimal: each holds 0 to 9, and when it advances from 9 it goes to 0.
- R2: The second tens and minute tens digits are base six: each holds 0 to 5, and when it advances from 5 it goes to 0.
- R3: The hour tens digit is one bit (0 or 1, upper three bits of its field always 0). It inverts each time the hour units digit rolls from 9 to 0. While it is 1, the hour units digit never exceeds 2.
- R4: A digit advances on an enabled edge only when every less significant digit holds its top value (9 for decimal digits, 5 for base-six digits). The second units digit advances on every enabled edge, except at the wrap.
- R5: An edge with `cnt_en` low and `rst` low leaves all six digits unchanged.
- R6: An enabled edge at 11:59:59 gives 12:00:00. The next enabled edge gives 00:00:00.
- R7: `rst` is synchronous and active high. An edge with `rst` high gives 00:00:00 whatever the value of `cnt_en`.
- R8: `bcd_o` packs the digits 4 bits each: [23:20] hour tens, [19:16] hour units, [15:12] minute tens, [11:8] minute units, [7:4] second tens, [3:0] second units.
- R9: `seg_o` packs 7-bit patterns in the same digit order, with hour tens at [41:35] down to second units at [6:0]. Each pattern is ordered {g,f,e,d,c,b,a}, and a 1 lights a segment. The patterns for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock; one enabled edge is one second |
| rst | input | 1 | Synchronous active-high clear to 00:00:00 |
| cnt_en | input | 1 | Count enable; when low the time holds |
| bcd_o | output | 24 | Six BCD digits, hour tens in the top field |
| seg_o | output | 42 | Six seven-segment patterns, hour tens in the top field |

## Verification
The assertions assume that `rst` is high at the first clock edge. They also assume that `rst` and `cnt_en` are stable two-valued levels at every rising edge, and that the digits can only reach legal time values from reset. The bench holds reset high from time zero. It changes the inputs only on falling edges and always drives them to 0 or 1. It steps the design through a full twelve-hour cycle plus directed pauses and resets, so every digit value and every carry path is reached from a cleared state.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int DIGIT_W    = 4;
    localparam int SEG_W      = 7;
    localparam int NUM_DIGITS = 6;
    localparam int DEC_LAST   = 9;
    localparam int SIX_LAST   = 5;
    localparam int WRAP_HT    = 1;
    localparam int WRAP_HU    = 2;

    typedef struct packed {
        logic [DIGIT_W-1:0] val;
    } stage_state_t;

    typedef struct packed {
        logic bit_v;
    } toggle_state_t;
endpackage

// File: rtl/tod_digit_stage.sv
module tod_digit_stage
    import tod_pkg::*;
#(
    parameter int W    = DIGIT_W,
    parameter int LAST = DEC_LAST
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] digit,
    output logic         carry
);
    localparam logic [W-1:0] LAST_V = LAST[W-1:0];

    logic [W-1:0] val_d, val_q;
    logic         at_top;

    always_comb begin
        at_top = (val_q == LAST_V);
        carry  = en && at_top;
        val_d  = val_q;
        if (rst || clr) begin
            val_d = '0;
        end else if (en) begin
            val_d = at_top ? '0 : val_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        val_q <= val_d;
    end

    assign digit = val_q;

    // R1 / R2: the digit never leaves its range
    a_r1_in_range: assert property (@(posedge clk) disable iff (rst)
        digit <= LAST_V);

    // R4: an enabled top value goes to zero
    a_r4_roll: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && digit == LAST_V) |=> digit == '0);

    // R4: an enabled value below the top goes up by one
    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && digit != LAST_V) |=> digit == $past(digit) + 1'b1);

    // R5: a disabled stage holds
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(digit));
endmodule

// File: rtl/tod_toggle_bit.sv
module tod_toggle_bit (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic bit_q
);
    logic t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (rst || clr) begin
            t_d = 1'b0;
        end else if (en) begin
            t_d = ~t_q;
        end
    end

    always_ff @(posedge clk) begin
        t_q <= t_d;
    end

    assign bit_q = t_q;

    // R3: an enable inverts the bit
    a_r3_toggle: assert property (@(posedge clk) disable iff (rst)
        (en && !clr) |=> bit_q != $past(bit_q));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(bit_q));
endmodule

// File: rtl/tod_seg_enc.sv
module tod_seg_enc
    import tod_pkg::*;
(
    input  logic [DIGIT_W-1:0] digit,
    output logic [SEG_W-1:0]   seg
);
    always_comb begin
        case (digit)
            4'd0:    seg = 7'h3F;
            4'd1:    seg = 7'h06;
            4'd2:    seg = 7'h5B;
            4'd3:    seg = 7'h4F;
            4'd4:    seg = 7'h66;
            4'd5:    seg = 7'h6D;
            4'd6:    seg = 7'h7D;
            4'd7:    seg = 7'h07;
            4'd8:    seg = 7'h7F;
            4'd9:    seg = 7'h6F;
            default: seg = 7'h00;
        endcase
    end

    // R9: a legal digit always lights at least two segments
    always_comb begin
        if (digit <= 4'd9) begin
            a_r9_lit: assert ($countones(seg) >= 2);
        end
    end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cnt_en,
    output logic [NUM_DIGITS*DIGIT_W-1:0] bcd_o,
    output logic [NUM_DIGITS*SEG_W-1:0]   seg_o
);
    localparam int CHAIN = NUM_DIGITS - 1;

    logic [DIGIT_W-1:0] dig [NUM_DIGITS];
    logic [CHAIN-1:0]   carry;
    logic [NUM_DIGITS-1:0] stage_en;
    logic               at_wrap;
    logic               wrap;
    logic               ht_bit;

    always_comb begin
        at_wrap = (dig[5] == DIGIT_W'(WRAP_HT)) && (dig[4] == DIGIT_W'(WRAP_HU))
               && (dig[3] == '0) && (dig[2] == '0)
               && (dig[1] == '0) && (dig[0] == '0);
        wrap        = cnt_en && at_wrap;
        stage_en[0] = cnt_en && !wrap;
        for (int i = 1; i < NUM_DIGITS; i++) begin
            stage_en[i] = carry[i-1];
        end
    end

    for (genvar i = 0; i < CHAIN; i++) begin : g_stage
        tod_digit_stage #(
            .W    (DIGIT_W),
            .LAST ((i % 2 == 0) ? DEC_LAST : SIX_LAST)
        ) u_stage (
            .clk   (clk),
            .rst   (rst),
            .clr   (wrap),
            .en    (stage_en[i]),
            .digit (dig[i]),
            .carry (carry[i])
        );
    end

    tod_toggle_bit u_hour_tens (
        .clk   (clk),
        .rst   (rst),
        .clr   (wrap),
        .en    (stage_en[5]),
        .bit_q (ht_bit)
    );

    assign dig[5] = {{(DIGIT_W-1){1'b0}}, ht_bit};

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_out
        assign bcd_o[i*DIGIT_W +: DIGIT_W] = dig[i];
        tod_seg_enc u_seg (
            .digit (dig[i]),
            .seg   (seg_o[i*SEG_W +: SEG_W])
        );
    end

    // R6: the enabled edge at the wrap value clears every digit
    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && bcd_o == 24'h120000) |=> bcd_o == '0);

    // R7: reset clears regardless of enable
    a_r7_reset: assert property (@(posedge clk)
        rst |=> bcd_o == '0);

    // R3: hours never pass twelve
    a_r3_hour_bound: assert property (@(posedge clk) disable iff (rst)
        (bcd_o[23:20] == 4'd1) |-> bcd_o[19:16] <= 4'd2);

    // R5: a disabled edge holds the whole time
    a_r5_freeze: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(bcd_o));
endmodule

// File: tb/tb_tod_counter.sv
module tb_tod_counter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic [23:0] bcd_o;
    logic [41:0] seg_o;

    int checks = 0;
    int fails  = 0;
    int secs   = 0;   // model: seconds since 00:00:00, range 0..43200

    always #5 clk = ~clk;

    tod_counter dut (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (cnt_en),
        .bcd_o  (bcd_o),
        .seg_o  (seg_o)
    );

    // row = {rst, en, cycles[15:0]}
    localparam int NROWS = 10;
    localparam logic [17:0] VEC [NROWS] = '{
        {1'b1, 1'b0, 16'd3},
        {1'b0, 1'b1, 16'd75},
        {1'b0, 1'b0, 16'd6},
        {1'b0, 1'b1, 16'd3700},
        {1'b1, 1'b1, 16'd2},
        {1'b0, 1'b1, 16'd610},
        {1'b0, 1'b0, 16'd3},
        {1'b0, 1'b1, 16'd36000},
        {1'b1, 1'b0, 16'd1},
        {1'b0, 1'b1, 16'd20}
    };

    function automatic logic [6:0] glyph(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic logic [23:0] exp_bcd(input int s);
        int h, m, c;
        h = s / 3600; m = (s / 60) % 60; c = s % 60;
        return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(c / 10), 4'(c % 10)};
    endfunction

    function automatic logic [41:0] exp_seg(input logic [23:0] b);
        logic [41:0] r;
        for (int i = 0; i < 6; i++) r[i*7 +: 7] = glyph(int'(b[i*4 +: 4]));
        return r;
    endfunction

    task automatic compare(input string tag);
        logic [23:0] eb;
        eb = exp_bcd(secs);
        checks++;
        if (bcd_o !== eb || seg_o !== exp_seg(eb)) begin
            fails++;
            $display("FAIL %s: bcd=%h seg=%h expected bcd=%h seg=%h",
                     tag, bcd_o, seg_o, eb, exp_seg(eb));
        end
    endtask

    task automatic step(input logic r, input logic e, input string tag);
        @(negedge clk);
        rst = r; cnt_en = e;
        @(posedge clk);
        if (r) secs = 0;
        else if (e) secs = (secs == 43200) ? 0 : secs + 1;
        #2;
        compare(tag);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        // R7: reset state
        step(1'b1, 1'b0, "R7 reset state");
        // table walk: R1 R2 R3 R4 R5 R7 R8 R9 checked each cycle
        for (int row = 0; row < NROWS; row++) begin
            for (int n = 0; n < int'(VEC[row][15:0]); n++) begin
                step(VEC[row][17], VEC[row][16], "R1/R2/R4/R8/R9 table");
            end
        end
        // R7: reset wins over enable
        step(1'b1, 1'b1, "R7 priority");
        // R1 R2: run to 00:09:59 then check carry into minute tens
        for (int n = 0; n < 599; n++) step(1'b0, 1'b1, "R2 count");
        step(1'b0, 1'b1, "R4 carry 00:10:00");
        // R3: cross 09:59:59 -> 10:00:00
        step(1'b1, 1'b0, "R7 clear");
        for (int n = 0; n < 35999; n++) step(1'b0, 1'b1, "R3 run");
        step(1'b0, 1'b1, "R3 hour tens toggles");
        // R6: approach 11:59:59
        for (int n = 0; n < 7199; n++) step(1'b0, 1'b1, "R6 run");
        step(1'b0, 1'b1, "R6 12:00:00 reached");
        // R5: pause while showing 12:00:00
        for (int n = 0; n < 4; n++) step(1'b0, 1'b0, "R5 hold at wrap");
        step(1'b0, 1'b1, "R6 wrap to 00:00:00");
        step(1'b0, 1'b1, "R6 after wrap");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule